// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block reproduces, beat by beat, the column order a synchronous DRAM walks through during one read or write burst. A controller or a memory behavioural model pulses a start strobe together with the first column, a burst-length code and a wrap-order bit. From the following cycle the block presents one column address per cycle, a valid flag and a flag that marks the final beat. A burst may be cut short by a burst-stop strobe or a precharge strobe. A new start strobe replaces the running burst at once, because the memory accepts a fresh column in every cycle.

The block is built around a three-state controller. `SQ_IDLE` means no burst is in progress. `SQ_FIXED` runs a burst of 1, 2, 4 or 8 beats. `SQ_PAGE` runs a full-page burst that only a stop, a precharge or a new start can end.

The transitions are:
- `SQ_IDLE` goes to `SQ_FIXED` or `SQ_PAGE` on a start.
- `SQ_FIXED` goes to `SQ_IDLE` on its final beat or on a stop or precharge.
- `SQ_PAGE` goes to `SQ_IDLE` on a stop or precharge.
- Either active state re-enters `SQ_FIXED` or `SQ_PAGE` on a start.
- Every other case holds the current state.

Top module: `sdram_burst_colseq`

## Requirements
- R1: While reset is asserted (`rst_n` low), and after it is released, `valid_o` and `last_o` are 0 until the first start.
- R2: In the cycle after `start_i` is sampled high, `valid_o` is 1 and `col_o` equals the sampled `start_col_i` (beat 0).
- R3: The burst-length code sets the beat count:
  - codes 0, 1, 2 and 3 select 1, 2, 4 and 8 beats;
  - code 7 selects full page;
  - the unused codes 4, 5 and 6 behave as a 1-beat burst.
- R4: In sequential order (`ilv_i` = 0), beat n of an L-beat burst is the start column with its low log2(L) bits replaced by (start + n) mod L. The burst therefore wraps inside its aligned L-column block.
- R5: In interleaved order (`ilv_i` = 1) on a fixed-length burst, beat n is the start column XOR n.
- R6: `last_o` is 1 together with `valid_o` on beat L-1 of a fixed-length burst. If no start is sampled in that cycle, `valid_o` is 0 in the next cycle.
- R7: A full-page burst steps the column by one per cycle modulo 1024 (1023 is followed by 0). It ignores `ilv_i`, never raises `last_o` by itself, and runs until it is ended.
- R8: While `valid_o` is 1, a high `stop_i` or `pre_i` makes `last_o` 1 in that same cycle. `valid_o` is 0 in the next cycle unless a start is sampled.
- R9: A start sampled while a burst is running abandons that burst. The next cycle shows beat 0 of the new burst.
- R10: `stop_i` and `pre_i` have no effect while no burst is running. A start sampled in the same cycle as a stop still begins its burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a burst at `start_col_i` |
| start_col_i | input | 10 | First column of the burst |
| blen_code_i | input | 3 | Burst-length code (see R3) |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | Burst-stop strobe |
| pre_i | input | 1 | Precharge strobe (also ends the burst) |
| col_o | output | 10 | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | This beat is the final one |

## Verification
The bench targets the following corner cases:
- Sequential bursts that start in the middle of their aligned block. A design that carries out of the block instead of wrapping would leave the block at the wrap point.
- Interleaved bursts from odd starts. These separate XOR from addition.
- A full-page burst that crosses column 1023, with the interleave bit set. A wrong design would stall, jump or XOR there.
- A start that arrives mid-burst. A wrong design would finish the old burst first.
- Stop and precharge in three situations: late in a burst, while idle, and in the same cycle as a start. A wrong design would drop `valid_o` late, start a phantom beat, or lose the new burst.
- The unused length codes. A design that read them as longer bursts would give itself away on the extra beats.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FIXED = 2'd1,
        SQ_PAGE  = 2'd2
    } sq_state_e;

endpackage

// File: rtl/colseq_len_decode.sv
module colseq_len_decode #(
    parameter int COL_W      = 10,
    parameter int CODE_W     = 3,
    parameter int FIXED_CODES = 4,
    parameter int PAGE_CODE  = 7
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              page_o
);
    // Fixed length 2**code for codes below FIXED_CODES; page code gives all
    // columns; everything else collapses to a single beat.
    always_comb begin
        mask_o = '0;
        page_o = 1'b0;
        if (int'(code_i) == PAGE_CODE) begin
            mask_o = '1;
            page_o = 1'b1;
        end else if (int'(code_i) < FIXED_CODES) begin
            for (int b = 0; b < COL_W; b++) begin
                if (b < int'(code_i)) mask_o[b] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;

    always_comb begin
        sum = base_i + beat_i;
        if (ilv_i) col_o = base_i ^ beat_i;
        else       col_o = (base_i & ~mask_i) | (sum & mask_i);
    end
endmodule

// File: rtl/colseq_ctrl.sv
module colseq_ctrl
    import colseq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] mask_in_i,
    input  logic             page_in_i,
    input  logic             ilv_in_i,
    input  logic             stop_i,
    input  logic             pre_i,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] mask_o,
    output logic             ilv_o,
    output logic             valid_o,
    output logic             last_o
);
    sq_state_e        state_q, state_d;
    logic [COL_W-1:0] beat_q, base_q, mask_q;
    logic             ilv_q;
    logic             cut;
    logic             fixed_end;

    assign cut       = stop_i | pre_i;
    assign fixed_end = (beat_q == mask_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = page_in_i ? SQ_PAGE : SQ_FIXED;
        end else begin
            unique case (state_q)
                SQ_IDLE:  state_d = SQ_IDLE;
                SQ_FIXED: state_d = (fixed_end || cut) ? SQ_IDLE : SQ_FIXED;
                SQ_PAGE:  state_d = cut ? SQ_IDLE : SQ_PAGE;
                default:  state_d = SQ_IDLE;
            endcase
        end
    end

    // state and burst context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                beat_q <= '0;
                base_q <= start_col_i;
                mask_q <= mask_in_i;
                ilv_q  <= ilv_in_i & ~page_in_i;
            end else if (state_q != SQ_IDLE) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        valid_o = 1'b0;
        last_o  = 1'b0;
        unique case (state_q)
            SQ_IDLE:  ;
            SQ_FIXED: begin valid_o = 1'b1; last_o = fixed_end | cut; end
            SQ_PAGE:  begin valid_o = 1'b1; last_o = cut; end
            default:  ;
        endcase
    end

    assign base_o = base_q;
    assign beat_o = beat_q;
    assign mask_o = mask_q;
    assign ilv_o  = ilv_q;

    a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);
    a_r6_end_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);
    a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && beat_q == '0));
    a_r7_page_no_self_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_PAGE && !cut) |-> !last_o);
    a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> !valid_o);
endmodule

// File: rtl/sdram_burst_colseq.sv
module sdram_burst_colseq #(
    parameter int COL_W       = 10,
    parameter int CODE_W      = 3,
    parameter int FIXED_CODES = 4,
    parameter int PAGE_CODE   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] blen_code_i,
    input  logic              ilv_i,
    input  logic              stop_i,
    input  logic              pre_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o
);
    logic [COL_W-1:0] dec_mask, base, beat, mask;
    logic             dec_page, ilv_eff;

    colseq_len_decode #(
        .COL_W(COL_W), .CODE_W(CODE_W),
        .FIXED_CODES(FIXED_CODES), .PAGE_CODE(PAGE_CODE)
    ) u_dec (
        .code_i (blen_code_i),
        .mask_o (dec_mask),
        .page_o (dec_page)
    );

    colseq_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .mask_in_i   (dec_mask),
        .page_in_i   (dec_page),
        .ilv_in_i    (ilv_i),
        .stop_i      (stop_i),
        .pre_i       (pre_i),
        .base_o      (base),
        .beat_o      (beat),
        .mask_o      (mask),
        .ilv_o       (ilv_eff),
        .valid_o     (valid_o),
        .last_o      (last_o)
    );

    colseq_addr_gen #(.COL_W(COL_W)) u_addr (
        .base_i (base),
        .beat_i (beat),
        .mask_i (mask),
        .ilv_i  (ilv_eff),
        .col_o  (col_o)
    );

    a_r2_first_col: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));
    a_r4_stays_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i) |=> (((col_o ^ $past(col_o)) & ~mask) == '0));
endmodule

// File: tb/sdram_burst_colseq_test.sv
`timescale 1ns/1ps
module sdram_burst_colseq_test;
    localparam int CYC = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [9:0] start_col_i = '0;
    logic [2:0] blen_code_i = '0;
    logic       ilv_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       pre_i = 1'b0;
    logic [9:0] col_o;
    logic       valid_o, last_o;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int m_act = 0, m_page = 0, m_start = 0, m_len = 1, m_ilv = 0, m_n = 0;

    always #(CYC/2) clk = ~clk;

    sdram_burst_colseq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_code_i(blen_code_i), .ilv_i(ilv_i), .stop_i(stop_i), .pre_i(pre_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    function automatic int exp_col();
        int off, base;
        if (m_page != 0) return (m_start + m_n) % 1024;
        if (m_ilv != 0)  return m_start ^ m_n;
        off  = m_start % m_len;
        base = m_start - off;
        return base + (off + m_n) % m_len;
    endfunction

    task automatic step(input string tag, input bit s, input int col, input int code,
                        input bit il, input bit stp, input bit pr);
        int ev, el, ec;
        @(negedge clk);
        start_i = s; start_col_i = 10'(col); blen_code_i = 3'(code);
        ilv_i = il; stop_i = stp; pre_i = pr;
        #1;
        ev = m_act;
        el = (m_act != 0) && (((m_page == 0) && (m_n == m_len - 1)) || stp || pr);
        ec = (m_act != 0) ? exp_col() : 0;
        n_cmp++;
        if (int'(valid_o) != ev || int'(last_o) != el ||
            (ev != 0 && int'(col_o) != ec)) begin
            n_bad++;
            $display("FAIL %s: valid/last/col got %0d/%0d/%0d exp %0d/%0d/%0d",
                     tag, valid_o, last_o, col_o, ev, el, ec);
        end
        @(posedge clk);
        if (s) begin
            m_act = 1; m_start = col; m_n = 0;
            m_page = (code == 7);
            m_len = (code < 4) ? (1 << code) : 1;
            m_ilv = (il && m_page == 0);
        end else if (m_act != 0) begin
            if (stp || pr || (m_page == 0 && m_n == m_len - 1)) m_act = 0;
            else m_n++;
        end
    endtask

    task automatic idle(input string tag, input int k);
        for (int i = 0; i < k; i++) step(tag, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic burst(input string tag, input int col, input int code,
                         input bit il, input int k);
        step(tag, 1, col, code, il, 0, 0);
        idle(tag, k);
    endtask

    initial begin
        #(CYC * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hang exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CYC * 2 + 3);
        n_cmp++;
        if (valid_o !== 1'b0 || last_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 in reset: valid/last got %0b/%0b exp 0/0", valid_o, last_o);
        end
        @(negedge clk); rst_n = 1'b1;
        idle("R1 after reset", 3);

        burst("R2 R3 R4 seq len1", 37, 0, 0, 2);
        burst("R3 R4 seq len2", 37, 1, 0, 3);
        burst("R4 R6 seq len4 mid", 6, 2, 0, 5);
        burst("R4 R6 seq len8 wrap", 13, 3, 0, 9);
        burst("R5 ilv len8", 13, 3, 1, 9);
        burst("R5 ilv len4", 1022, 2, 1, 5);
        burst("R5 ilv len2", 5, 1, 1, 3);
        burst("R3 unused code5", 100, 5, 0, 3);
        burst("R3 unused code4", 200, 4, 1, 3);
        burst("R3 unused code6", 300, 6, 0, 3);

        // full page across the top column, ilv ignored
        step("R7 page start", 1, 1020, 7, 1, 0, 0);
        idle("R7 page run", 1100);
        step("R8 page stop", 0, 0, 0, 0, 1, 0);
        idle("R8 after stop", 3);

        // precharge ends a fixed burst early
        step("R8 pre start", 1, 40, 3, 0, 0, 0);
        idle("R8 pre run", 2);
        step("R8 pre cut", 0, 0, 0, 0, 0, 1);
        idle("R8 after pre", 3);

        // pre-emption
        step("R9 first", 1, 64, 3, 0, 0, 0);
        idle("R9 run", 2);
        step("R9 restart", 1, 514, 2, 1, 0, 0);
        idle("R9 new", 5);
        step("R9 page", 1, 3, 7, 0, 0, 0);
        idle("R9 page run", 4);
        step("R9 restart page", 1, 900, 3, 0, 0, 0);
        idle("R9 after", 9);

        // stop/pre ignored while idle; start with stop same cycle
        step("R10 stop idle", 0, 0, 0, 0, 1, 0);
        step("R10 pre idle", 0, 0, 0, 0, 0, 1);
        idle("R10 quiet", 2);
        step("R10 run", 1, 70, 3, 0, 0, 0);
        idle("R10 run", 1);
        step("R10 start+stop", 1, 80, 2, 0, 1, 0);
        idle("R10 new burst", 5);
        step("R10 start+pre idle", 1, 90, 1, 1, 0, 1);
        idle("R10 tail", 4);

        // back-to-back start on the last beat
        step("R6 chain a", 1, 8, 1, 0, 0, 0);
        step("R6 chain b", 0, 0, 0, 0, 0, 0);
        step("R6 chain c", 1, 33, 1, 1, 0, 0);
        idle("R6 chain end", 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule